// File: doc/BRIEF.md
# Zero-Suppressing Channel Readout Sequencer

This block holds one conversion's worth of results from a 16-channel bank, each result 11 bits wide, and answers read commands for them. A pulse on `conv_valid` captures the whole bank in one cycle. If `ped_en` is high at that moment, the block subtracts a per-channel pedestal from each value, clamping at zero. `clear` throws the held bank away.

Each cycle in which `rd_strobe` is high is answered one clock later with a 16-bit word on `rd_word` and an accept flag `q`. In random mode (`seq_mode` = 0), `subaddr` picks the channel. In sequential mode (`seq_mode` = 1), an internal read position picks the word and `subaddr` has no effect. The position steps forward once the strobe of an accepted read drops.

With `comp_en` set in sequential mode, the sequence starts with a header word that carries an 8-bit module identifier and the number of words that follow. After the header, only channels holding a nonzero value are returned, each tagged with its channel number. When no channel survives, no read is accepted.

Top module: `rdseq_top`

## Requirements
- R1: After a synchronous reset, `q` is low, `rd_word` is zero, and no bank is held, so any read is refused.
- R2: In random mode, `q` is high only if a bank has been captured and no `clear` has come since. The word is the value of channel `subaddr` in bits [10:0], with bits [15:11] zero. Zero values are returned as well.
- R3: In sequential mode with `comp_en` low, reads return channels 0 through 15 in that order. Each word has the value in bits [10:0] and zeros in bits [15:11], and `subaddr` has no effect.
- R4: While `rd_strobe` stays high, the same word is returned on every cycle. The sequential position advances only after the strobe of an accepted read falls.
- R5: In sequential mode with `comp_en` high, the first word is a header. Bits [7:0] hold `module_id`, bits [10:8] are zero, bits [14:11] hold the number of surviving channels minus one (0 means one word, 15 means sixteen), and bit [15] is 1.
- R6: After the header, only channels with a nonzero value are returned, in ascending channel order. Each word has the value in bits [10:0], the channel number in bits [14:11], and bit [15] at 0.
- R7: In sequential mode with `comp_en` high, no read is accepted when every channel is zero.
- R8: With `ped_en` high at capture, each stored value is the raw value minus its pedestal, or zero if the raw value does not exceed the pedestal. The zero test in R6 and R7 uses the stored value.
- R9: After the last word of a sequence has been read, further sequential reads return `q` low and a zero word. A new capture restarts the sequence from its first word, and a `clear` refuses all reads until the next capture.
- R10: A response appears on the clock edge that samples `rd_strobe` high. On any edge that samples the strobe low, `q` drops to 0 and `rd_word` to zero.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle pulse that captures a new bank |
| clear | input | 1 | Discards the held bank |
| raw_bus | input | 176 | Raw values, channel c in bits [11c+10:11c] |
| ped_bus | input | 176 | Pedestals, laid out the same way as `raw_bus` |
| ped_en | input | 1 | Apply pedestal subtraction at capture |
| comp_en | input | 1 | Zero suppression with header in sequential mode |
| seq_mode | input | 1 | 0 for random access, 1 for sequential |
| module_id | input | 8 | Identifier placed in the header |
| rd_strobe | input | 1 | Read command, held high for the duration of a read |
| subaddr | input | 4 | Channel select in random mode |
| rd_word | output | 16 | Read word |
| q | output | 1 | Read accepted |

## Verification
The properties assume that `seq_mode`, `comp_en`, `subaddr` and `module_id` only change while `rd_strobe` is low. They also assume that `clear` and `conv_valid` never arrive while a read is in progress. The stability property for a held strobe relies on these assumptions. The bench drives every mode change, capture and clear in a cycle where the strobe is low, and it holds `subaddr` fixed for the length of each read. In sequential mode the bench still changes `subaddr` between reads, to show that it has no effect.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int NUM_CH = 16;
    localparam int VAL_W  = 11;
    localparam int ID_W   = 8;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int WORD_W = 1 + CH_W + VAL_W;
    localparam int BUS_W  = NUM_CH * VAL_W;

    // Read word layout: flag, tag, body
    typedef struct packed {
        logic             hdr;
        logic [CH_W-1:0]  tag;
        logic [VAL_W-1:0] body;
    } word_t;

    // Result of a set-bit search
    typedef struct packed {
        logic            found;
        logic [CH_W-1:0] idx;
    } hit_t;

    typedef enum logic [1:0] {
        SRC_DIRECT,
        SRC_PLAIN,
        SRC_HEADER,
        SRC_TAGGED
    } src_e;

    typedef logic [NUM_CH-1:0][VAL_W-1:0] bank_t;

    // Lowest set bit of m at or above start
    function automatic hit_t first_from(input logic [NUM_CH-1:0] m,
                                        input logic [CH_W:0]     start);
        hit_t h;
        h = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i] && ((CH_W + 1)'(i) >= start)) begin
                h.found = 1'b1;
                h.idx   = CH_W'(i);
            end
        end
        return h;
    endfunction

    // Subtraction clamped at zero
    function automatic logic [VAL_W-1:0] sub_sat(input logic [VAL_W-1:0] a,
                                                 input logic [VAL_W-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    function automatic word_t make_header(input logic [ID_W-1:0] id,
                                          input logic [CH_W-1:0] cnt_m1);
        word_t w;
        w.hdr  = 1'b1;
        w.tag  = cnt_m1;
        w.body = VAL_W'(id);
        return w;
    endfunction

endpackage

// File: rtl/rdseq_capture.sv
module rdseq_capture
    import rdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_valid,
    input  logic              clear,
    input  logic              ped_en,
    input  logic [BUS_W-1:0]  raw_bus,
    input  logic [BUS_W-1:0]  ped_bus,
    output bank_t             vals,
    output logic [NUM_CH-1:0] keep_mask,
    output logic [CH_W-1:0]   cnt_m1,
    output logic              has_data
);

    bank_t          next_vals;
    logic [CH_W:0]  pop;

    // One subtractor and one zero test per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [VAL_W-1:0] raw_c;
        logic [VAL_W-1:0] ped_c;
        assign raw_c        = raw_bus[c*VAL_W +: VAL_W];
        assign ped_c        = ped_bus[c*VAL_W +: VAL_W];
        assign next_vals[c] = ped_en ? sub_sat(raw_c, ped_c) : raw_c;
        assign keep_mask[c] = (vals[c] != '0);
    end

    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            pop = pop + (CH_W + 1)'(keep_mask[i]);
        end
    end

    assign cnt_m1 = CH_W'(pop - (CH_W + 1)'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            vals     <= '0;
            has_data <= 1'b0;
        end else if (clear) begin
            has_data <= 1'b0;
        end else if (conv_valid) begin
            vals     <= next_vals;
            has_data <= 1'b1;
        end
    end

endmodule

// File: rtl/rdseq_pointer.sv
module rdseq_pointer
    import rdseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_valid,
    input  logic              clear,
    input  logic              adv,
    input  logic              seq_mode,
    input  logic              comp_en,
    input  logic [NUM_CH-1:0] keep_mask,
    output logic [CH_W-1:0]   ptr,
    output logic              hdr_pend,
    output logic              done
);

    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

    hit_t first_hit;
    hit_t next_hit;

    assign first_hit = first_from(keep_mask, '0);
    assign next_hit  = first_from(keep_mask, {1'b0, ptr} + (CH_W + 1)'(1));

    always_ff @(posedge clk) begin
        if (rst || clear || conv_valid) begin
            ptr      <= '0;
            hdr_pend <= 1'b1;
            done     <= 1'b0;
        end else if (adv && seq_mode && !done) begin
            if (comp_en) begin
                if (hdr_pend) begin
                    hdr_pend <= 1'b0;
                    ptr      <= first_hit.idx;
                end else if (next_hit.found) begin
                    ptr <= next_hit.idx;
                end else begin
                    done <= 1'b1;
                end
            end else begin
                if (ptr == LAST) begin
                    done <= 1'b1;
                end else begin
                    ptr <= ptr + CH_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rdseq_format.sv
module rdseq_format
    import rdseq_pkg::*;
(
    input  logic              seq_mode,
    input  logic              comp_en,
    input  logic [CH_W-1:0]   subaddr,
    input  logic [ID_W-1:0]   module_id,
    input  logic [CH_W-1:0]   ptr,
    input  logic              hdr_pend,
    input  logic              done,
    input  logic              has_data,
    input  bank_t             vals,
    input  logic [NUM_CH-1:0] keep_mask,
    input  logic [CH_W-1:0]   cnt_m1,
    output word_t             word_n,
    output logic              q_n
);

    src_e src;

    always_comb begin
        if (!seq_mode) begin
            src = SRC_DIRECT;
        end else if (!comp_en) begin
            src = SRC_PLAIN;
        end else if (hdr_pend) begin
            src = SRC_HEADER;
        end else begin
            src = SRC_TAGGED;
        end
    end

    always_comb begin
        word_n = '0;
        q_n    = 1'b0;
        unique case (src)
            SRC_DIRECT: begin
                q_n         = has_data;
                word_n.body = vals[subaddr];
            end
            SRC_PLAIN: begin
                q_n         = has_data && !done;
                word_n.body = vals[ptr];
            end
            SRC_HEADER: begin
                q_n    = has_data && !done && (|keep_mask);
                word_n = make_header(module_id, cnt_m1);
            end
            SRC_TAGGED: begin
                q_n         = has_data && !done && (|keep_mask);
                word_n.tag  = ptr;
                word_n.body = vals[ptr];
            end
            default: begin
                q_n    = 1'b0;
                word_n = '0;
            end
        endcase
    end

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
    import rdseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_valid,
    input  logic                clear,
    input  logic [BUS_W-1:0]    raw_bus,
    input  logic [BUS_W-1:0]    ped_bus,
    input  logic                ped_en,
    input  logic                comp_en,
    input  logic                seq_mode,
    input  logic [ID_W-1:0]     module_id,
    input  logic                rd_strobe,
    input  logic [CH_W-1:0]     subaddr,
    output logic [WORD_W-1:0]   rd_word,
    output logic                q
);

    bank_t             vals;
    logic [NUM_CH-1:0] keep_mask;
    logic [CH_W-1:0]   cnt_m1;
    logic              has_data;
    logic [CH_W-1:0]   ptr;
    logic              hdr_pend;
    logic              done;
    word_t             word_n;
    logic              q_n;
    logic              strb_d;
    logic              adv;

    // An accepted read ends when its strobe drops
    assign adv = strb_d && !rd_strobe && q;

    rdseq_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .conv_valid (conv_valid),
        .clear      (clear),
        .ped_en     (ped_en),
        .raw_bus    (raw_bus),
        .ped_bus    (ped_bus),
        .vals       (vals),
        .keep_mask  (keep_mask),
        .cnt_m1     (cnt_m1),
        .has_data   (has_data)
    );

    rdseq_pointer u_ptr (
        .clk        (clk),
        .rst        (rst),
        .conv_valid (conv_valid),
        .clear      (clear),
        .adv        (adv),
        .seq_mode   (seq_mode),
        .comp_en    (comp_en),
        .keep_mask  (keep_mask),
        .ptr        (ptr),
        .hdr_pend   (hdr_pend),
        .done       (done)
    );

    rdseq_format u_fmt (
        .seq_mode   (seq_mode),
        .comp_en    (comp_en),
        .subaddr    (subaddr),
        .module_id  (module_id),
        .ptr        (ptr),
        .hdr_pend   (hdr_pend),
        .done       (done),
        .has_data   (has_data),
        .vals       (vals),
        .keep_mask  (keep_mask),
        .cnt_m1     (cnt_m1),
        .word_n     (word_n),
        .q_n        (q_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= 1'b0;
            rd_word <= '0;
            strb_d  <= 1'b0;
        end else begin
            strb_d <= rd_strobe;
            if (rd_strobe) begin
                q       <= q_n;
                rd_word <= q_n ? word_n : '0;
            end else begin
                q       <= 1'b0;
                rd_word <= '0;
            end
        end
    end

endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk
    import rdseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              conv_valid,
    input logic              clear,
    input logic              comp_en,
    input logic              seq_mode,
    input logic [ID_W-1:0]   module_id,
    input logic              rd_strobe,
    input logic [CH_W-1:0]   subaddr,
    input logic [WORD_W-1:0] rd_word,
    input logic              q,
    input logic              has_data,
    input logic [NUM_CH-1:0] keep_mask
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> (!q && rd_word == '0)); // R10

    AST_NO_DATA_NO_Q: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !has_data) |=> !q); // R2

    AST_RANDOM_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !seq_mode) |=> (rd_word[WORD_W-1:VAL_W] == '0)); // R2

    AST_PLAIN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && seq_mode && !comp_en) |=> (rd_word[WORD_W-1:VAL_W] == '0)); // R3

    AST_HEADER_GAP: assert property (@(posedge clk) disable iff (rst)
        (q && rd_word[WORD_W-1]) |-> (rd_word[VAL_W-1:ID_W] == '0)); // R5

    AST_ZERO_SUPPRESSED: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && seq_mode && comp_en) |=>
            (!q || rd_word[WORD_W-1] || rd_word[VAL_W-1:0] != '0)); // R6

    AST_EMPTY_NO_Q: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && seq_mode && comp_en && keep_mask == '0) |=> !q); // R7

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && $past(rd_strobe) && $stable(subaddr) && $stable(seq_mode)
         && $stable(comp_en) && $stable(module_id) && !clear && !conv_valid
         && !$past(clear) && !$past(conv_valid))
        |=> ($stable(rd_word) && $stable(q))); // R4

endmodule

bind rdseq_top rdseq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_valid (conv_valid),
    .clear      (clear),
    .comp_en    (comp_en),
    .seq_mode   (seq_mode),
    .module_id  (module_id),
    .rd_strobe  (rd_strobe),
    .subaddr    (subaddr),
    .rd_word    (rd_word),
    .q          (q),
    .has_data   (has_data),
    .keep_mask  (keep_mask)
);

// File: tb/sim_rdseq_top.sv
module sim_rdseq_top;
    import rdseq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              conv_valid = 1'b0;
    logic              clear = 1'b0;
    logic [BUS_W-1:0]  raw_bus = '0;
    logic [BUS_W-1:0]  ped_bus = '0;
    logic              ped_en = 1'b0;
    logic              comp_en = 1'b0;
    logic              seq_mode = 1'b0;
    logic [ID_W-1:0]   module_id = 8'hA5;
    logic              rd_strobe = 1'b0;
    logic [CH_W-1:0]   subaddr = '0;
    logic [WORD_W-1:0] rd_word;
    logic              q;

    int n_chk  = 0;
    int n_fail = 0;
    logic [VAL_W-1:0] raw_v [NUM_CH];
    logic [VAL_W-1:0] ped_v [NUM_CH];

    always #2 clk = ~clk;

    rdseq_top u0 (
        .clk(clk), .rst(rst), .conv_valid(conv_valid), .clear(clear),
        .raw_bus(raw_bus), .ped_bus(ped_bus), .ped_en(ped_en),
        .comp_en(comp_en), .seq_mode(seq_mode), .module_id(module_id),
        .rd_strobe(rd_strobe), .subaddr(subaddr), .rd_word(rd_word), .q(q)
    );

    // Random-mode lookup: {subaddr, expected word}; all expect q high
    localparam logic [19:0] RND_TAB [6] = '{
        {4'd1,  16'h0123},
        {4'd0,  16'h0000},
        {4'd3,  16'h07FF},
        {4'd15, 16'h0055},
        {4'd5,  16'h0001},
        {4'd9,  16'h0400}
    };

    task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got q=%0b word=%h, expected q=%0b word=%h",
                     tag, got[16], got[15:0], exp[16], exp[15:0]);
        end
    endtask

    task automatic load(input logic pe);
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) begin
            raw_bus[c*VAL_W +: VAL_W] = raw_v[c];
            ped_bus[c*VAL_W +: VAL_W] = ped_v[c];
        end
        ped_en = pe;
        conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic rd(output logic [16:0] r);
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        r = {q, rd_word};
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_pattern();
        for (int c = 0; c < NUM_CH; c++) begin
            raw_v[c] = '0;
            ped_v[c] = 11'd2;
        end
        raw_v[1] = 11'h123; raw_v[3] = 11'h7FF; raw_v[5] = 11'h001;
        raw_v[9] = 11'h400; raw_v[15] = 11'h055;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [16:0] r;
        logic [16:0] e;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", {q, rd_word}, 17'h0);
        rd(r);
        chk("R1 R2 read before capture", r, 17'h0);

        // Random mode, table walk
        set_pattern();
        load(1'b0);
        for (int i = 0; i < 6; i++) begin
            subaddr = RND_TAB[i][19:16];
            rd(r);
            chk("R2 random read", r, {1'b1, RND_TAB[i][15:0]});
        end
        @(negedge clk);
        chk("R10 strobe low", {q, rd_word}, 17'h0);

        // Clear refuses reads
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        subaddr = 4'd1;
        rd(r);
        chk("R2 R9 read after clear", r, 17'h0);

        // Sequential uncompressed
        load(1'b0);
        seq_mode = 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
            subaddr = CH_W'(NUM_CH - 1 - c);
            rd(r);
            chk("R3 plain sequential", r, {1'b1, 5'b0, raw_v[c]});
        end
        rd(r);
        chk("R9 plain past end", r, 17'h0);

        // Sequential compressed
        comp_en = 1'b1;
        load(1'b0);
        rd(r);
        chk("R5 header", r, {1'b1, 16'hA0A5});
        for (int c = 0; c < NUM_CH; c++) begin
            if (raw_v[c] != '0) begin
                subaddr = 4'd7;
                rd(r);
                chk("R6 tagged word", r, {1'b1, 1'b0, 4'(c), raw_v[c]});
            end
        end
        rd(r);
        chk("R9 compressed past end", r, 17'h0);

        // Held strobe returns the same word; advances once
        load(1'b0);
        @(negedge clk); rd_strobe = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 held strobe", {q, rd_word}, {1'b1, 16'hA0A5});
        end
        rd_strobe = 1'b0;
        @(negedge clk);
        rd(r);
        chk("R4 single advance", r, {1'b1, 16'h0923});

        // New capture restarts sequence
        load(1'b0);
        rd(r);
        chk("R9 restart on capture", r, {1'b1, 16'hA0A5});

        // Pedestal subtraction with compression
        load(1'b1);
        rd(r);
        chk("R8 header with pedestal", r, {1'b1, 16'h98A5});
        rd(r); chk("R8 ch1", r, {1'b1, 16'h0921});
        rd(r); chk("R8 ch3", r, {1'b1, 16'h1FFD});
        rd(r); chk("R8 ch9 (ch5 clamped)", r, {1'b1, 16'h4BFE});
        rd(r); chk("R8 ch15", r, {1'b1, 16'h7853});
        rd(r); chk("R9 pedestal past end", r, 17'h0);

        // Pedestal in random mode
        seq_mode = 1'b0;
        comp_en = 1'b0;
        subaddr = 4'd0; rd(r); chk("R8 random ch0 clamp", r, {1'b1, 16'h0000});
        subaddr = 4'd9; rd(r); chk("R8 random ch9", r, {1'b1, 16'h03FE});
        subaddr = 4'd5; rd(r); chk("R8 random ch5", r, {1'b1, 16'h0000});

        // All channels empty
        for (int c = 0; c < NUM_CH; c++) raw_v[c] = '0;
        seq_mode = 1'b1;
        comp_en = 1'b1;
        load(1'b0);
        rd(r);
        chk("R7 empty bank", r, 17'h0);

        // All sixteen survive
        for (int c = 0; c < NUM_CH; c++) raw_v[c] = 11'(c + 1);
        load(1'b0);
        rd(r);
        chk("R5 full count header", r, {1'b1, 16'hF8A5});
        for (int c = 0; c < NUM_CH; c++) begin
            rd(r);
            e = {1'b1, 1'b0, 4'(c), 11'(c + 1)};
            chk("R6 full sequence", r, e);
        end
        rd(r);
        chk("R9 full past end", r, 17'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule